// File: doc/BRIEF.md
# Toggle-Count Response Engine

This block gives a challenge-free response bit the way a ring-oscillator comparison circuit does, but it uses only clocked logic. A 32-bit maximal-length shift register runs on every clock. Sixteen toggle flip-flops each flip on a different two-bit XOR of that register, so each one has its own pseudo-random toggle pattern. Pairs of neighbouring flip-flops feed pairs of 12-bit counters. Each counter adds the level of its flip-flop on every cycle of a fixed counting window.

A three-state sequencer runs the same loop for as long as reset is released: one setup cycle, 1000 counting cycles, then one report cycle. In the report cycle each counter pair produces an "A greater than B" bit. The eight bits are folded by XOR and then whitened with a shift-register bit and a bit of a running CRC-8. The block raises a one-cycle done strobe in that cycle. Six debug lines show whitened counter bits captured at each report. A consumer samples the response bit in the cycle where done is high.

Top module: `ropuf_engine`

## Requirements
- R1: The 32-bit shift register resets to 0x00000001. On every clock edge, in every sequencer state, it becomes {s[30:0], s[31]^s[21]^s[1]^s[0]}.
- R2: Toggle flip-flop j (0 to 15) resets to 0. On each edge it inverts when s[j]^s[j+16] is 1 and holds otherwise.
- R3: In every counting cycle, counter A of pair k adds toggle bit 2k and counter B adds toggle bit 2k+1. A counter never exceeds the number of counting cycles elapsed and stops at 4095 instead of wrapping. Both counters clear on the edge that leaves the setup state.
- R4: After reset the sequencer is in setup. Setup lasts one cycle, counting lasts exactly 1000 cycles and report lasts one cycle. Report then returns to setup, so the first done is high after the 1001st edge following reset release.
- R5: done_o is high for exactly one cycle per measurement. Successive pulses are exactly 1002 cycles apart.
- R6: During report, resp_o equals the XOR over k of (A_k > B_k), XORed with shift-register bit 0 and CRC bit 0, using the values held in that cycle. In all other cycles resp_o is 0.
- R7: The CRC-8 resets to 0. On each report edge it takes in the comparison XOR b as follows: f = c[7]^b, then c becomes {c[6:0],0} XOR (f ? 0x07 : 0x00).
- R8: The debug output resets to 0. On each report edge bit i (0 to 5) loads A_i[9] ^ B_i[9] ^ s[i]. Between report edges it holds its value.
- R9: Asserting rst_ni low clears done_o, resp_o and dbg_o at once, without waiting for a clock. After release a full new measurement starts from setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, hold at least 5 cycles |
| resp_o | output | 1 | Response bit, valid while done_o is high |
| done_o | output | 1 | One-cycle end-of-measurement strobe |
| dbg_o | output | 6 | Whitened counter bits captured at each report |

## Verification
Several properties are checked on every cycle. The done strobe is a single cycle and pulses are exactly 1002 cycles apart. The response stays quiet outside report. The debug lines hold between reports. No counter ever runs ahead of the elapsed window count. The shift register never reaches the all-zero lock-up state, and report always follows a full window and hands back to setup. Only the bench's scenarios can show that the response and debug values are correct. To do this, the bench runs an independent cycle model through consecutive measurements, several reset lengths and resets in the middle of a window. These scenarios also exercise the CRC history, which carries across measurements.

// File: rtl/ropuf_pkg.sv
package ropuf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } meas_state_e;

    localparam int LFSR_W = 32;
    localparam int CRC_W  = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

    // Fibonacci step, feedback from taps 32, 22, 2, 1 (1-based)
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // One serial CRC step, MSB-first
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/ropuf_lfsr.sv
module ropuf_lfsr
    import ropuf_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 32'h0000_0001
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    output logic [LFSR_W-1:0] state_o
);

    typedef struct packed {
        logic [LFSR_W-1:0] sr;
    } lfsr_regs_t;

    lfsr_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.sr = lfsr_step(r_q.sr);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.sr <= SEED;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.sr;

endmodule

// File: rtl/ropuf_toggle_bank.sv
module ropuf_toggle_bank
    import ropuf_pkg::*;
#(
    parameter int NUM_FF = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [LFSR_W-1:0] lfsr_i,
    output logic [NUM_FF-1:0] tff_o
);

    typedef struct packed {
        logic [NUM_FF-1:0] t;
    } tff_regs_t;

    tff_regs_t   r_d, r_q;
    logic [NUM_FF-1:0] flip;

    // each flip-flop sees its own pair of shift-register bits
    for (genvar j = 0; j < NUM_FF; j++) begin : g_flip
        assign flip[j] = lfsr_i[j] ^ lfsr_i[j + NUM_FF];
    end

    always_comb begin
        r_d   = r_q;
        r_d.t = r_q.t ^ flip;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.t <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tff_o = r_q.t;

endmodule

// File: rtl/ropuf_pair_counter.sv
module ropuf_pair_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             count_i,
    input  logic             a_bit_i,
    input  logic             b_bit_i,
    output logic [CNT_W-1:0] cnt_a_o,
    output logic [CNT_W-1:0] cnt_b_o,
    output logic             a_gt_b_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] a;
        logic [CNT_W-1:0] b;
    } pair_regs_t;

    pair_regs_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (clear_i) begin
            p_d.a = '0;
            p_d.b = '0;
        end else if (count_i) begin
            if (a_bit_i && (p_q.a != CNT_MAX)) p_d.a = p_q.a + 1'b1;
            if (b_bit_i && (p_q.b != CNT_MAX)) p_d.b = p_q.b + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            p_q.a <= '0;
            p_q.b <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign cnt_a_o  = p_q.a;
    assign cnt_b_o  = p_q.b;
    assign a_gt_b_o = (p_q.a > p_q.b);

endmodule

// File: rtl/ropuf_engine.sv
module ropuf_engine
    import ropuf_pkg::*;
#(
    parameter int                NUM_PAIRS = 8,
    parameter int                CNT_W     = 12,
    parameter int                WINDOW    = 1000,
    parameter int                DBG_W     = 6,
    parameter logic [LFSR_W-1:0] SEED      = 32'h0000_0001
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic             resp_o,
    output logic             done_o,
    output logic [DBG_W-1:0] dbg_o
);

    localparam int NUM_FF  = 2 * NUM_PAIRS;
    localparam int WIN_W   = $clog2(WINDOW + 1);
    localparam int DBG_BIT = $clog2(WINDOW) - 1;   // highest bit a full window can reach

    typedef struct packed {
        meas_state_e      state;
        logic [WIN_W-1:0] win;
        logic [CRC_W-1:0] crc;
        logic [DBG_W-1:0] dbg;
    } ctrl_regs_t;

    ctrl_regs_t c_d, c_q;

    logic [LFSR_W-1:0]    lfsr_w;
    logic [NUM_FF-1:0]    tff_w;
    logic [CNT_W-1:0]     cnt_a [NUM_PAIRS];
    logic [CNT_W-1:0]     cnt_b [NUM_PAIRS];
    logic [NUM_PAIRS-1:0] a_gt_b;
    logic [DBG_W-1:0]     dbg_mix;
    logic                 clear_cnt;
    logic                 count_en;
    logic                 cmp_x;

    ropuf_lfsr #(.SEED(SEED)) u_lfsr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .state_o (lfsr_w)
    );

    ropuf_toggle_bank #(.NUM_FF(NUM_FF)) u_tff (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lfsr_i (lfsr_w),
        .tff_o  (tff_w)
    );

    assign clear_cnt = (c_q.state == ST_IDLE);
    assign count_en  = (c_q.state == ST_RUN);

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        ropuf_pair_counter #(.CNT_W(CNT_W)) u_pair (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .clear_i  (clear_cnt),
            .count_i  (count_en),
            .a_bit_i  (tff_w[2*k]),
            .b_bit_i  (tff_w[2*k+1]),
            .cnt_a_o  (cnt_a[k]),
            .cnt_b_o  (cnt_b[k]),
            .a_gt_b_o (a_gt_b[k])
        );
    end

    for (genvar i = 0; i < DBG_W; i++) begin : g_dbg
        assign dbg_mix[i] = cnt_a[i][DBG_BIT] ^ cnt_b[i][DBG_BIT] ^ lfsr_w[i];
    end

    assign cmp_x = ^a_gt_b;

    always_comb begin
        c_d = c_q;
        unique case (c_q.state)
            ST_IDLE: begin
                c_d.state = ST_RUN;
                c_d.win   = '0;
            end
            ST_RUN: begin
                c_d.win = c_q.win + 1'b1;
                if (c_q.win == WIN_W'(WINDOW - 1)) c_d.state = ST_DONE;
            end
            ST_DONE: begin
                c_d.state = ST_IDLE;
                c_d.crc   = crc_step(c_q.crc, cmp_x);
                c_d.dbg   = dbg_mix;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q.state <= ST_IDLE;
            c_q.win   <= '0;
            c_q.crc   <= '0;
            c_q.dbg   <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign done_o = (c_q.state == ST_DONE);
    assign resp_o = done_o & (cmp_x ^ lfsr_w[0] ^ c_q.crc[0]);
    assign dbg_o  = c_q.dbg;

endmodule

// File: rtl/ropuf_engine_chk.sv
module ropuf_engine_chk
    import ropuf_pkg::*;
#(
    parameter int NUM_PAIRS = 8,
    parameter int CNT_W     = 12,
    parameter int WINDOW    = 1000,
    parameter int DBG_W     = 6,
    parameter int WIN_W     = 10
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              done_i,
    input logic              resp_i,
    input logic [DBG_W-1:0]  dbg_i,
    input logic [1:0]        state_i,
    input logic [WIN_W-1:0]  win_i,
    input logic [LFSR_W-1:0] lfsr_i,
    input logic [CNT_W-1:0]  cnt_a_i [NUM_PAIRS],
    input logic [CNT_W-1:0]  cnt_b_i [NUM_PAIRS]
);

    localparam int PERIOD = WINDOW + 2;

    logic [31:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (done_i) begin
            gap_q  <= 32'd1;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 32'd1;
        end
    end

    p_lfsr_live_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lfsr_i != '0);

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_bound
        p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (state_i != ST_IDLE) |->
                (32'(cnt_a_i[k]) <= 32'(win_i)) && (32'(cnt_b_i[k]) <= 32'(win_i)));
    end

    p_full_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> (32'(win_i) == WINDOW));

    p_back_to_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> (state_i == ST_IDLE));

    p_single_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> !done_i);

    p_pulse_spacing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && seen_q) |-> (gap_q == PERIOD));

    p_resp_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_i |-> !resp_i);

    p_dbg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(done_i) |-> $stable(dbg_i));

endmodule

bind ropuf_engine ropuf_engine_chk #(
    .NUM_PAIRS (NUM_PAIRS),
    .CNT_W     (CNT_W),
    .WINDOW    (WINDOW),
    .DBG_W     (DBG_W),
    .WIN_W     (WIN_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (done_o),
    .resp_i  (resp_o),
    .dbg_i   (dbg_o),
    .state_i (c_q.state),
    .win_i   (c_q.win),
    .lfsr_i  (lfsr_w),
    .cnt_a_i (cnt_a),
    .cnt_b_i (cnt_b)
);

// File: tb/ropuf_engine_test.sv
module ropuf_engine_test;

    localparam int NP     = 8;
    localparam int WIN    = 1000;
    localparam int DW     = 6;
    localparam int PERIOD = WIN + 2;
    localparam int DBGB   = 9;
    localparam int CMAX   = 4095;

    // scenario table: reset length, measurements to observe, extra cycles before next reset
    localparam int ROWS = 4;
    localparam int RST_LEN [ROWS] = '{5, 6, 9, 5};
    localparam int MEAS    [ROWS] = '{3, 1, 2, 1};
    localparam int TAIL    [ROWS] = '{0, 417, 0, 1001};

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic resp, done;
    logic [DW-1:0] dbg;

    always #5 clk = ~clk;

    ropuf_engine uut (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .resp_o (resp),
        .done_o (done),
        .dbg_o  (dbg)
    );

    // ---------------- reference model built from the requirements ----------------
    logic [31:0]   m_sr;
    logic [15:0]   m_t;
    int            m_a [NP];
    int            m_b [NP];
    int            m_st;      // 0 setup, 1 counting, 2 report
    int            m_w;
    logic [7:0]    m_crc;
    logic [DW-1:0] m_dbg;

    function automatic logic m_cmp();
        logic x = 1'b0;
        for (int k = 0; k < NP; k++) x = x ^ (m_a[k] > m_b[k]);
        return x;
    endfunction

    function automatic logic [7:0] m_crc_next(input logic [7:0] c, input logic b);
        logic [7:0] r = {c[6:0], 1'b0};
        if (c[7] ^ b) r = r ^ 8'h07;
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sr  <= 32'h1;
            m_t   <= '0;
            for (int k = 0; k < NP; k++) begin
                m_a[k] <= 0;
                m_b[k] <= 0;
            end
            m_st  <= 0;
            m_w   <= 0;
            m_crc <= '0;
            m_dbg <= '0;
        end else begin
            m_sr <= {m_sr[30:0], m_sr[31] ^ m_sr[21] ^ m_sr[1] ^ m_sr[0]};
            for (int j = 0; j < 16; j++) m_t[j] <= m_t[j] ^ m_sr[j] ^ m_sr[j+16];
            case (m_st)
                0: begin
                    m_st <= 1;
                    m_w  <= 0;
                    for (int k = 0; k < NP; k++) begin
                        m_a[k] <= 0;
                        m_b[k] <= 0;
                    end
                end
                1: begin
                    for (int k = 0; k < NP; k++) begin
                        if (m_a[k] < CMAX) m_a[k] <= m_a[k] + int'(m_t[2*k]);
                        if (m_b[k] < CMAX) m_b[k] <= m_b[k] + int'(m_t[2*k+1]);
                    end
                    m_w <= m_w + 1;
                    if (m_w == WIN - 1) m_st <= 2;
                end
                default: begin
                    m_st  <= 0;
                    m_crc <= m_crc_next(m_crc, m_cmp());
                    for (int i = 0; i < DW; i++)
                        m_dbg[i] <= ((m_a[i] >> DBGB) & 1) ^ ((m_b[i] >> DBGB) & 1) ^ m_sr[i];
                end
            endcase
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0;
    int n_bad = 0;
    int gap   = 0;
    int done_cnt = 0;
    bit first = 1'b1;
    int cyc   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            logic exp_resp;
            gap++;
            exp_resp = (m_st == 2) ? (m_cmp() ^ m_sr[0] ^ m_crc[0]) : 1'b0;
            chk("R4 done level", 32'(done), 32'(m_st == 2));
            chk("R6 response (via R1 R2 R3 R7)", 32'(resp), 32'(exp_resp));
            chk("R8 debug value", 32'(dbg), 32'(m_dbg));
            if (m_st == 2) begin
                chk(first ? "R4 first pulse delay" : "R5 pulse spacing",
                    32'(gap), first ? 32'(WIN + 1) : 32'(PERIOD));
                gap   = 0;
                first = 1'b0;
                done_cnt++;
            end
        end
    end

    task automatic do_reset(input int n);
        @(negedge clk);
        #1 rst_n = 1'b0;
        #1;
        chk("R9 done cleared", 32'(done), 32'd0);
        chk("R9 resp cleared", 32'(resp), 32'd0);
        chk("R9 dbg cleared",  32'(dbg),  32'd0);
        repeat (n) @(negedge clk);
        #1;
        gap   = 0;
        first = 1'b1;
        rst_n = 1'b1;
    endtask

    task automatic wait_pulses(input int n);
        int target = done_cnt + n;
        while (done_cnt < target) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<=60000", cyc);
            finish_run();
        end
    end

    initial begin
        // reset state before any release (R9)
        #2;
        chk("R9 done low in reset", 32'(done), 32'd0);
        chk("R9 dbg zero in reset", 32'(dbg),  32'd0);

        // table-driven scenarios
        for (int r = 0; r < ROWS; r++) begin
            do_reset(RST_LEN[r]);
            wait_pulses(MEAS[r]);
            repeat (TAIL[r]) @(negedge clk);
        end

        // directed: reset in the middle of a window, nonzero debug held before it (R9)
        do_reset(5);
        wait_pulses(1);
        repeat (600) @(negedge clk);
        chk("R8 debug held mid-window", 32'(dbg), 32'(m_dbg));
        #2 rst_n = 1'b0;
        #1;
        chk("R9 async clear done", 32'(done), 32'd0);
        chk("R9 async clear dbg",  32'(dbg),  32'd0);
        repeat (5) @(negedge clk);
        #1;
        gap   = 0;
        first = 1'b1;
        rst_n = 1'b1;
        wait_pulses(2);

        // directed: done strobe lasts one cycle (R5)
        @(negedge clk);
        chk("R5 done dropped after one cycle", 32'(done), 32'd0);

        finish_run();
    end

endmodule